// File: doc/BRIEF.md
# Bit-Addressed Interrupt Mask and Priority Encoder

This block watches fifteen active-low interrupt lines, numbered 1 to 15, and turns them into a single active-low request and a 4-bit code that names the most urgent line. Each line is brought into the system clock domain by a two-flop synchroniser. It then passes a further holding register before its arm bit gates it. Only lines that are armed and driven low take part in the request and in the code. The lowest index wins.

Software reaches the block through a one-bit-wide register port: a bit address, a write strobe with one data bit, and one read data bit. The same bit address means two different things. A write loads the arm bit of that line. A read returns the synchronised pin level of that line, armed or not. Bit address 0 belongs to the mode control and is never an interrupt line. A neighbouring timer block supplies a mode input. While that input selects clock mode, the timer owns bit addresses 1 to 15: this block ignores writes and leaves the read bit undriven.

Top module: `irq_mask_prio`

## Requirements
- R1: After reset all arm bits are 0, `req_no` is 1 and `prio_o` is 4'b1111.
- R2: In interrupt mode (`clk_mode_i`=0), a write with `wr_en_i`=1 at bit address n (1..15) loads arm bit n from `wr_data_i` (1 arms, 0 disarms). The outputs reflect the new mask one clock after the write edge.
- R3: In interrupt mode, a read at bit address n (1..15) sets `rd_en_o`=1 and returns the synchronised level of line n on `rd_data_o` (1 = inactive), armed or not. A pin change is visible there two clock edges after it happens.
- R4: `req_no` is 0 exactly when at least one armed line is low. A pin change reaches `req_no` and `prio_o` after four clock edges: two synchroniser stages, the holding register and the output register.
- R5: While a request is raised, `prio_o` holds the smallest index among the armed low lines as a 4-bit unsigned number. For example, lines 4 and 7 together give 4'b0100. With no such line it holds 4'b1111.
- R6: A low line whose arm bit is 0 leaves `req_no` and `prio_o` unchanged.
- R7: Bit address 0 is not an interrupt line: writes there change no arm bit, and reads give `rd_en_o`=0 and `rd_data_o`=0.
- R8: In clock mode (`clk_mode_i`=1), writes change no arm bit, and `rd_en_o` and `rd_data_o` stay 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| clk_mode_i | input | 1 | 1 = clock mode, taken from the timer block |
| addr_i | input | 4 | Bit address |
| wr_en_i | input | 1 | Write strobe for one bit |
| wr_data_i | input | 1 | Write data bit (arm value) |
| irq_ni | input | 15 | Interrupt lines 15..1, active low |
| rd_en_o | output | 1 | This block drives the read bit |
| rd_data_o | output | 1 | Read data: synchronised pin level |
| req_no | output | 1 | Interrupt request, active low |
| prio_o | output | 4 | Index of the lowest armed active line |

## Verification
Each result has a fixed latency. The read bit follows a pin two edges after the pin changes. The request and the code follow a pin after four edges. They follow a mask write one edge after the write edge. The driver changes inputs just after a rising edge and waits exactly that number of edges before it queues the expected values. The monitor compares them at the next falling edge. The checks of both latencies also sample one edge early and expect the old value there.

// File: rtl/irq_pkg.sv
package irq_pkg;
  localparam int unsigned IRQ_CNT_DEF = 15;

  typedef enum logic {
    MODE_INT = 1'b0,
    MODE_CLK = 1'b1
  } mode_e;
endpackage

// File: rtl/irq_in_stage.sv
// Two-flop synchroniser plus holding register per line; all reset to inactive (1).
module irq_in_stage #(
  parameter int unsigned N_IRQ = 15
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [N_IRQ:1]   irq_ni,
  output logic [N_IRQ:1]   lvl_o,
  output logic [N_IRQ:1]   held_o
);
  for (genvar i = 1; i <= N_IRQ; i++) begin : g_line
    logic s1_q, s2_q, h_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        s1_q <= 1'b1;
        s2_q <= 1'b1;
        h_q  <= 1'b1;
      end else begin
        s1_q <= irq_ni[i];
        s2_q <= s1_q;
        h_q  <= s2_q;
      end
    end
    assign lvl_o[i]  = s2_q;
    assign held_o[i] = h_q;
  end
endmodule

// File: rtl/irq_arm_regs.sv
module irq_arm_regs #(
  parameter int unsigned N_IRQ  = 15,
  parameter int unsigned ADDR_W = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              data_i,
  output logic [N_IRQ:1]    arm_o
);
  for (genvar i = 1; i <= N_IRQ; i++) begin : g_arm
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) arm_o[i] <= 1'b0;
      else if (we_i && (addr_i == ADDR_W'(i))) arm_o[i] <= data_i;
    end
  end
endmodule

// File: rtl/irq_prio_enc.sv
// Lowest set index wins; all ones when nothing is set.
module irq_prio_enc #(
  parameter int unsigned N_IRQ  = 15,
  parameter int unsigned PRIO_W = 4
) (
  input  logic [N_IRQ:1]    act_i,
  output logic              any_o,
  output logic [PRIO_W-1:0] code_o
);
  always_comb begin
    any_o  = 1'b0;
    code_o = '1;
    for (int i = N_IRQ; i >= 1; i--) begin
      if (act_i[i]) begin
        any_o  = 1'b1;
        code_o = PRIO_W'(i);
      end
    end
  end
endmodule

// File: rtl/irq_mask_prio.sv
module irq_mask_prio
  import irq_pkg::*;
#(
  parameter int unsigned N_IRQ  = IRQ_CNT_DEF,
  parameter int unsigned ADDR_W = $clog2(N_IRQ + 1),
  parameter int unsigned PRIO_W = $clog2(N_IRQ + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clk_mode_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              wr_en_i,
  input  logic              wr_data_i,
  input  logic [N_IRQ:1]    irq_ni,
  output logic              rd_en_o,
  output logic              rd_data_o,
  output logic              req_no,
  output logic [PRIO_W-1:0] prio_o
);
  localparam int unsigned MAP_SZ = 2 ** ADDR_W;

  mode_e                mode;
  logic                 sel;
  logic [N_IRQ:1]       lvl, held, arm_q, act;
  logic [MAP_SZ-1:0]    lvl_map;
  logic                 any;
  logic [PRIO_W-1:0]    code;

  assign mode = mode_e'(clk_mode_i);
  assign sel  = (mode == MODE_INT) && (addr_i != '0) && (int'(addr_i) <= N_IRQ);

  irq_in_stage #(.N_IRQ(N_IRQ)) i_in (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .irq_ni (irq_ni),
    .lvl_o  (lvl),
    .held_o (held)
  );

  irq_arm_regs #(.N_IRQ(N_IRQ), .ADDR_W(ADDR_W)) i_arm (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .we_i   (wr_en_i && sel),
    .addr_i (addr_i),
    .data_i (wr_data_i),
    .arm_o  (arm_q)
  );

  assign act = arm_q & ~held;

  irq_prio_enc #(.N_IRQ(N_IRQ), .PRIO_W(PRIO_W)) i_enc (
    .act_i  (act),
    .any_o  (any),
    .code_o (code)
  );

  // Padded read map so any address indexes a defined bit.
  always_comb begin
    lvl_map = '1;
    lvl_map[N_IRQ:1] = lvl;
  end

  assign rd_en_o   = sel;
  assign rd_data_o = sel & lvl_map[addr_i];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      req_no <= 1'b1;
      prio_o <= '1;
    end else begin
      req_no <= ~any;
      prio_o <= code;
    end
  end
endmodule

// File: rtl/irq_mask_prio_chk.sv
module irq_mask_prio_chk #(
  parameter int unsigned N_IRQ  = 15,
  parameter int unsigned ADDR_W = 4,
  parameter int unsigned PRIO_W = 4
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              clk_mode_i,
  input logic [ADDR_W-1:0] addr_i,
  input logic              wr_en_i,
  input logic              wr_data_i,
  input logic [N_IRQ:1]    arm_q,
  input logic              rd_en_o,
  input logic              rd_data_o,
  input logic              req_no,
  input logic [PRIO_W-1:0] prio_o
);
  logic legal_wr;
  assign legal_wr = wr_en_i && !clk_mode_i && (addr_i != '0) && (int'(addr_i) <= N_IRQ);

  AST_IDLE_CODE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_no |-> (prio_o == '1)); // R5
  AST_REQ_CODE_NONZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !req_no |-> (prio_o != '0)); // R5
  AST_ARM_LOAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    legal_wr |=> (arm_q[$past(addr_i)] == $past(wr_data_i))); // R2
  AST_CLK_MODE_NO_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clk_mode_i && wr_en_i) |=> $stable(arm_q)); // R8
  AST_ADDR0_NO_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (addr_i == '0 && wr_en_i) |=> $stable(arm_q)); // R7
  AST_CLK_MODE_NO_DRIVE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clk_mode_i |-> !rd_en_o); // R8
  AST_UNDRIVEN_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_en_o |-> !rd_data_o); // R7
  AST_UNARMED_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (arm_q == '0 && $past(arm_q) == '0) |=> req_no); // R6
endmodule

bind irq_mask_prio irq_mask_prio_chk #(
  .N_IRQ(N_IRQ), .ADDR_W(ADDR_W), .PRIO_W(PRIO_W)
) i_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .clk_mode_i(clk_mode_i), .addr_i(addr_i),
  .wr_en_i(wr_en_i), .wr_data_i(wr_data_i), .arm_q(arm_q), .rd_en_o(rd_en_o),
  .rd_data_o(rd_data_o), .req_no(req_no), .prio_o(prio_o)
);

// File: tb/test_irq_mask_prio.sv
`timescale 1ns/1ps
module test_irq_mask_prio;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        clk_mode_i = 1'b0;
  logic [3:0]  addr_i = '0;
  logic        wr_en_i = 1'b0;
  logic        wr_data_i = 1'b0;
  logic [15:1] irq_ni = '1;
  logic        rd_en_o, rd_data_o, req_no;
  logic [3:0]  prio_o;

  irq_mask_prio i_irq_mask_prio (.*);

  always #2.5 clk_i = ~clk_i;

  typedef struct {
    string      tag;
    bit         chk_out;
    logic       req;
    logic [3:0] prio;
    bit         chk_rd;
    logic       rd_en;
    logic       rd_data;
  } item_t;

  item_t       q[$];
  int          total = 0;
  int          bad = 0;
  logic [15:1] arm_m = '0;
  logic [15:1] lvl_m = '1;

  function automatic logic [3:0] exp_prio(logic [15:1] arm, logic [15:1] lvl);
    for (int i = 1; i <= 15; i++) if (arm[i] && !lvl[i]) return 4'(i);
    return 4'hF;
  endfunction

  task automatic step(int n = 1);
    repeat (n) @(posedge clk_i);
    #1;
  endtask

  task automatic push_out(string tag, logic [15:1] arm, logic [15:1] lvl);
    item_t it;
    it.tag = tag; it.chk_out = 1'b1; it.chk_rd = 1'b0;
    it.prio = exp_prio(arm, lvl);
    it.req = (arm & ~lvl) == '0;
    it.rd_en = 1'b0; it.rd_data = 1'b0;
    q.push_back(it);
  endtask

  task automatic push_rd(string tag, logic en, logic d);
    item_t it;
    it.tag = tag; it.chk_out = 1'b0; it.chk_rd = 1'b1;
    it.req = 1'b1; it.prio = '1; it.rd_en = en; it.rd_data = d;
    q.push_back(it);
  endtask

  task automatic wr(logic [3:0] a, logic d);
    addr_i = a; wr_data_i = d; wr_en_i = 1'b1;
    step();
    wr_en_i = 1'b0;
  endtask

  always @(negedge clk_i) begin
    while (q.size() > 0) begin
      item_t it;
      it = q.pop_front();
      if (it.chk_out) begin
        total++;
        if (req_no !== it.req || prio_o !== it.prio) begin
          bad++;
          $display("FAIL %s: req=%b prio=%h expected req=%b prio=%h",
                   it.tag, req_no, prio_o, it.req, it.prio);
        end
      end
      if (it.chk_rd) begin
        total++;
        if (rd_en_o !== it.rd_en || rd_data_o !== it.rd_data) begin
          bad++;
          $display("FAIL %s: rd_en=%b rd_data=%b expected rd_en=%b rd_data=%b",
                   it.tag, rd_en_o, rd_data_o, it.rd_en, it.rd_data);
        end
      end
    end
  end

  task automatic finish_run();
    step(2);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    #500us;
    bad++;
    $display("FAIL watchdog: run hung, expected completion");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    step(3);
    push_out("R1 reset outputs", arm_m, lvl_m);
    step();
    rst_ni = 1'b1;
    step(2);
    push_out("R1 outputs after reset release", arm_m, lvl_m);
    addr_i = 4'd1; #0; push_rd("R3 read line 1 idle", 1'b1, 1'b1);
    step();
    addr_i = 4'd15; push_rd("R3 read line 15 idle", 1'b1, 1'b1);
    step();

    // lines 4 and 7 low, none armed
    irq_ni[4] = 1'b0; irq_ni[7] = 1'b0; lvl_m[4] = 1'b0; lvl_m[7] = 1'b0;
    addr_i = 4'd4;
    step(1);
    push_rd("R3 read not yet synced after 1 edge", 1'b1, 1'b1);
    step(1);
    push_rd("R3 read line 4 low after 2 edges", 1'b1, 1'b0);
    step(3);
    push_out("R6 unarmed low lines ignored", arm_m, lvl_m);

    // arm 7: visible one edge after the write edge
    wr(4'd7, 1'b1);
    push_out("R2 arm not yet visible at write edge", '0, lvl_m);
    arm_m[7] = 1'b1;
    step();
    push_out("R2 R4 arm line 7", arm_m, lvl_m);
    wr(4'd4, 1'b1); arm_m[4] = 1'b1;
    step();
    push_out("R5 lines 4 and 7 give 4", arm_m, lvl_m);
    wr(4'd4, 1'b0); arm_m[4] = 1'b0;
    step();
    push_out("R2 disarm line 4 gives 7", arm_m, lvl_m);

    // clock mode: write ignored, read not driven
    irq_ni[2] = 1'b0; lvl_m[2] = 1'b0;
    step(5);
    clk_mode_i = 1'b1;
    wr(4'd2, 1'b1);
    push_rd("R8 clock mode read undriven", 1'b0, 1'b0);
    step();
    push_out("R8 clock mode write ignored", arm_m, lvl_m);
    clk_mode_i = 1'b0;

    // address 0 reserved
    wr(4'd0, 1'b1);
    push_rd("R7 addr 0 read undriven", 1'b0, 1'b0);
    step();
    push_out("R7 addr 0 write ignored", arm_m, lvl_m);
    addr_i = 4'd2; #0; push_rd("R3 R8 line 2 read unarmed", 1'b1, 1'b0);
    step();
    push_out("R8 line 2 still unarmed", arm_m, lvl_m);

    // pin-to-output latency
    wr(4'd1, 1'b1); arm_m[1] = 1'b1;
    step();
    push_out("R2 arm line 1 while high", arm_m, lvl_m);
    irq_ni[1] = 1'b0;
    step(3);
    push_out("R4 line 1 not yet after 3 edges", arm_m, lvl_m);
    lvl_m[1] = 1'b0;
    step(1);
    push_out("R4 line 1 after 4 edges", arm_m, lvl_m);

    // release everything
    irq_ni = '1; lvl_m = '1;
    step(4);
    push_out("R4 R5 all released", arm_m, lvl_m);

    // highest index alone
    wr(4'd15, 1'b1); arm_m[15] = 1'b1;
    irq_ni[15] = 1'b0; lvl_m[15] = 1'b0;
    step(5);
    push_out("R5 only line 15 gives 15", arm_m, lvl_m);
    wr(4'd15, 1'b0); arm_m[15] = 1'b0;
    step();
    push_out("R2 disarm 15 drops request", arm_m, lvl_m);

    finish_run();
  end
endmodule